// File: doc/BRIEF.md
# Memory Scan Compare Engine

This block searches memory for a value equal to an accumulator operand. When started, it takes its starting address from one of several pointer registers and reads one byte or one 16-bit word per step. It compares the operand with the accumulator by subtracting the operand from the accumulator. The difference is thrown away and only the condition flags are kept. After each compare the pointer moves up or down by the operand size, and a 16-bit count is decremented. The overflow flag is replaced by a flag that shows whether the count is still non-zero.

In single mode the engine makes exactly one compare. In repeat mode it keeps scanning until the accumulator matches, which sets the zero flag, or until the count runs out. A memory-abort input suppresses the compare for a step: the flags hold their values, but the pointer, the count and the count flag still advance. The block also reports a cycle total for the operation, so that a timing model can charge the right cost. The block never writes memory.

Top module: `mem_scan_cmp`

## Requirements
- R1: After synchronous reset the block is idle. `busy_o`, `done_o` and `mem_rd_en_o` are low, and `ptr_o`, `count_o`, `flags_o` and `cycles_o` are zero.
- R2: A `start_i` pulse while idle loads the pointer selected by `ptr_sel_i` from `ptr_bank_i`, where entry k occupies bits [k*AW +: AW]. It also latches the other operation inputs. Each step drives one read cycle (`mem_rd_en_o` high for one clock) at the current pointer. `mem_rdata_i` is expected one clock after that read cycle.
- R3: In byte mode (`word_i`=0) each step forms acc[7:0] − rdata[7:0]. `flags_o` holds the flags as {S,Z,H,V,N,C}, with S in bit 5 and C in bit 0. S is bit 7 of the difference, Z is set when the difference is zero, H is the borrow out of bit 3, N is 1, and C is the borrow out of bit 7.
- R4: In word mode (`word_i`=1) the compare uses all 16 bits. S is bit 15 of the difference and C is the borrow out of bit 15. H is still the borrow out of bit 3.
- R5: After each step the pointer moves by 1 in byte mode or by 2 in word mode. It moves down when `dir_down_i`=1 and up otherwise, and it wraps modulo 2^AW.
- R6: Each step decrements the count modulo 2^16 and sets V (bit 2) to show that the new count is non-zero. A start count of 0 therefore leaves 16'hFFFF with V=1.
- R7: With `repeat_i`=1 the engine takes another step only while V=1 and Z=0. With `repeat_i`=0 it makes exactly one step.
- R8: `cycles_o` reports 8 for a single compare and 10 + 14·n for a repeated compare of n steps.
- R9: When `mem_abort_i` is high in the clock where read data returns, S, Z, H, N and C keep their values, and the held Z is the one the repeat exit test uses. The pointer, the count and V still advance.
- R10: `busy_o` is high from the clock after an accepted start until the operation ends. `done_o` is a one-clock pulse, and the final pointer, count, flags and cycle total are valid in that same clock. A `start_i` that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation when idle |
| ptr_sel_i | input | $clog2(NPTR) | Index of the pointer register that gives the start address |
| word_i | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| dir_down_i | input | 1 | 1 = pointer moves down |
| repeat_i | input | 1 | 1 = repeat until match or count exhausted |
| acc_i | input | DW | Accumulator value compared against memory |
| count_i | input | CW | Initial count |
| ptr_bank_i | input | NPTR*AW | Flattened pointer register bank |
| mem_abort_i | input | 1 | Suppress the compare and flag update for the returning step |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Memory read address |
| mem_rdata_i | input | DW | Read data, one clock after the strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock end-of-operation pulse |
| ptr_o | output | AW | Final pointer |
| count_o | output | CW | Final count |
| flags_o | output | 6 | {S,Z,H,V,N,C} |
| cycles_o | output | CYCW | Cycle total of the operation |

## Verification
The assertions assume that `start_i` starts from zero under reset and that read data arrives exactly one clock after each strobe. The bench holds both: it drives `start_i` only at falling edges, and its byte-wide memory model registers a 16-bit little-endian word on each strobe. The exit and count checks also assume that repeat operations use small non-zero counts, so the bench draws counts between 1 and 24 and uses a start count of 0 only in single mode. Memory bytes and accumulator values are drawn from a narrow range, so that both matches and exhausted scans occur. The abort line is held steady for a whole operation.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CMP  = 2'd2
  } scan_state_e;

  // Bit 5 = S ... bit 0 = C
  typedef struct packed {
    logic s;
    logic z;
    logic h;
    logic v;
    logic n;
    logic c;
  } scan_flags_t;

  localparam int unsigned CYC_SINGLE   = 8;
  localparam int unsigned CYC_REP_BASE = 10;
  localparam int unsigned CYC_REP_STEP = 14;

endpackage

// File: rtl/mscan_ptr_pick.sv
module mscan_ptr_pick #(
  parameter int unsigned NPTR = 8,
  parameter int unsigned AW   = 24,
  localparam int unsigned SELW = $clog2(NPTR)
) (
  input  logic [NPTR*AW-1:0] bank_i,
  input  logic [SELW-1:0]    sel_i,
  output logic [AW-1:0]      ptr_o
);

  logic [AW-1:0] entry [NPTR];

  for (genvar k = 0; k < NPTR; k++) begin : g_unpack
    assign entry[k] = bank_i[k*AW +: AW];
  end

  always_comb begin
    ptr_o = '0;
    for (int k = 0; k < NPTR; k++) begin
      if (sel_i == SELW'(k)) ptr_o = entry[k];
    end
  end

endmodule

// File: rtl/mscan_sub_flags.sv
module mscan_sub_flags #(
  parameter int unsigned DW = 16,
  localparam int unsigned HB = DW / 2
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          word_i,
  output logic          s_o,
  output logic          z_o,
  output logic          h_o,
  output logic          n_o,
  output logic          c_o
);

  logic [DW:0] diff_w;
  logic [HB:0] diff_b;
  logic        nib_borrow;

  assign diff_w     = {1'b0, acc_i} - {1'b0, opnd_i};
  assign diff_b     = {1'b0, acc_i[HB-1:0]} - {1'b0, opnd_i[HB-1:0]};
  assign nib_borrow = acc_i[3:0] < opnd_i[3:0];

  always_comb begin
    n_o = 1'b1;
    h_o = nib_borrow;
    if (word_i) begin
      s_o = diff_w[DW-1];
      z_o = (diff_w[DW-1:0] == '0);
      c_o = diff_w[DW];
    end else begin
      s_o = diff_b[HB-1];
      z_o = (diff_b[HB-1:0] == '0);
      c_o = diff_b[HB];
    end
  end

endmodule

// File: rtl/mscan_step.sv
module mscan_step #(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input  logic [AW-1:0] ptr_i,
  input  logic          word_i,
  input  logic          dir_down_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          nz_o
);

  logic [AW-1:0] stride;

  assign stride = word_i ? AW'(2) : AW'(1);
  assign ptr_o  = dir_down_i ? (ptr_i - stride) : (ptr_i + stride);
  assign cnt_o  = cnt_i - CW'(1);
  assign nz_o   = (cnt_o != '0);

endmodule

// File: rtl/mem_scan_cmp.sv
module mem_scan_cmp #(
  parameter int unsigned AW   = 24,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned NPTR = 8,
  parameter int unsigned CYCW = 24,
  localparam int unsigned SELW = $clog2(NPTR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [SELW-1:0]    ptr_sel_i,
  input  logic               word_i,
  input  logic               dir_down_i,
  input  logic               repeat_i,
  input  logic [DW-1:0]      acc_i,
  input  logic [CW-1:0]      count_i,
  input  logic [NPTR*AW-1:0] ptr_bank_i,
  input  logic               mem_abort_i,
  output logic               mem_rd_en_o,
  output logic [AW-1:0]      mem_addr_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [AW-1:0]      ptr_o,
  output logic [CW-1:0]      count_o,
  output logic [5:0]         flags_o,
  output logic [CYCW-1:0]    cycles_o
);
  import mscan_pkg::*;

  scan_state_e   state_q;
  scan_flags_t   flags_q;
  logic          word_q, down_q, rep_q;
  logic [DW-1:0] acc_q;
  logic [AW-1:0] ptr_q, addr_q;
  logic [CW-1:0] cnt_q;
  logic [CYCW-1:0] cyc_q;
  logic          rd_en_q, done_q;

  logic [AW-1:0] start_ptr, ptr_nx;
  logic [CW-1:0] cnt_nx;
  logic          cnt_nz;
  logic          sub_s, sub_z, sub_h, sub_n, sub_c;
  logic          z_eff, keep_going;

  mscan_ptr_pick #(.NPTR(NPTR), .AW(AW)) u_pick (
    .bank_i (ptr_bank_i),
    .sel_i  (ptr_sel_i),
    .ptr_o  (start_ptr)
  );

  mscan_sub_flags #(.DW(DW)) u_sub (
    .acc_i  (acc_q),
    .opnd_i (mem_rdata_i),
    .word_i (word_q),
    .s_o    (sub_s),
    .z_o    (sub_z),
    .h_o    (sub_h),
    .n_o    (sub_n),
    .c_o    (sub_c)
  );

  mscan_step #(.AW(AW), .CW(CW)) u_step (
    .ptr_i      (ptr_q),
    .word_i     (word_q),
    .dir_down_i (down_q),
    .cnt_i      (cnt_q),
    .ptr_o      (ptr_nx),
    .cnt_o      (cnt_nx),
    .nz_o       (cnt_nz)
  );

  // Zero flag seen by the loop test: the fresh one, or the held one on abort
  assign z_eff      = mem_abort_i ? flags_q.z : sub_z;
  assign keep_going = rep_q && cnt_nz && !z_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      word_q  <= 1'b0;
      down_q  <= 1'b0;
      rep_q   <= 1'b0;
      acc_q   <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      cyc_q   <= '0;
      rd_en_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            word_q  <= word_i;
            down_q  <= dir_down_i;
            rep_q   <= repeat_i;
            acc_q   <= acc_i;
            ptr_q   <= start_ptr;
            cnt_q   <= count_i;
            cyc_q   <= repeat_i ? CYCW'(CYC_REP_BASE) : CYCW'(CYC_SINGLE);
            rd_en_q <= 1'b1;
            addr_q  <= start_ptr;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          rd_en_q <= 1'b0;
          state_q <= ST_CMP;
        end
        ST_CMP: begin
          ptr_q     <= ptr_nx;
          cnt_q     <= cnt_nx;
          flags_q.v <= cnt_nz;
          if (!mem_abort_i) begin
            flags_q.s <= sub_s;
            flags_q.z <= sub_z;
            flags_q.h <= sub_h;
            flags_q.n <= sub_n;
            flags_q.c <= sub_c;
          end
          if (rep_q) cyc_q <= cyc_q + CYCW'(CYC_REP_STEP);
          if (keep_going) begin
            rd_en_q <= 1'b1;
            addr_q  <= ptr_nx;
            state_q <= ST_WAIT;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en_o = rd_en_q;
  assign mem_addr_o  = addr_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign ptr_o       = ptr_q;
  assign count_o     = cnt_q;
  assign flags_o     = flags_q;
  assign cycles_o    = cyc_q;

endmodule

// File: rtl/mem_scan_cmp_chk.sv
module mem_scan_cmp_chk #(
  parameter int unsigned CW   = 16,
  parameter int unsigned CYCW = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_rd_en_o,
  input logic [CW-1:0]   count_o,
  input logic [5:0]      flags_o,
  input logic [CYCW-1:0] cycles_o,
  input logic            rep_q
);

  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en_o |-> busy_o); // R2

  AST_RD_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en_o |=> !mem_rd_en_o); // R2

  AST_V_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (flags_o[2] == (count_o != '0))); // R6

  AST_REPEAT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (done_o && rep_q) |-> ((count_o == '0) || flags_o[4])); // R7

  AST_SINGLE_COST: assert property (@(posedge clk) disable iff (rst)
    (done_o && !rep_q) |-> (cycles_o == CYCW'(8))); // R8

  AST_REPEAT_COST: assert property (@(posedge clk) disable iff (rst)
    (done_o && rep_q) |-> (cycles_o >= CYCW'(24))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10

  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R10

endmodule

bind mem_scan_cmp mem_scan_cmp_chk #(.CW(CW), .CYCW(CYCW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_rd_en_o (mem_rd_en_o),
  .count_o     (count_o),
  .flags_o     (flags_o),
  .cycles_o    (cycles_o),
  .rep_q       (rep_q)
);

// File: tb/mem_scan_cmp_bench.sv
module mem_scan_cmp_bench;

  localparam int AW = 24, DW = 16, CW = 16, NPTR = 8, CYCW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic            start_i = 1'b0;
  logic [2:0]      ptr_sel_i = '0;
  logic            word_i = 1'b0, dir_down_i = 1'b0, repeat_i = 1'b0;
  logic [DW-1:0]   acc_i = '0;
  logic [CW-1:0]   count_i = '0;
  logic [NPTR*AW-1:0] ptr_bank_i;
  logic            mem_abort_i = 1'b0;
  logic            mem_rd_en_o;
  logic [AW-1:0]   mem_addr_o;
  logic [DW-1:0]   mem_rdata_i = '0;
  logic            busy_o, done_o;
  logic [AW-1:0]   ptr_o;
  logic [CW-1:0]   count_o;
  logic [5:0]      flags_o;
  logic [CYCW-1:0] cycles_o;

  logic [AW-1:0] bank [NPTR];
  logic [7:0]    mem  [1024];

  always_comb begin
    for (int k = 0; k < NPTR; k++) ptr_bank_i[k*AW +: AW] = bank[k];
  end

  always_ff @(posedge clk) begin
    if (mem_rd_en_o)
      mem_rdata_i <= {mem[mem_addr_o[9:0] + 10'd1], mem[mem_addr_o[9:0]]};
  end

  mem_scan_cmp u_mem_scan_cmp (
    .clk(clk), .rst(rst), .start_i(start_i), .ptr_sel_i(ptr_sel_i),
    .word_i(word_i), .dir_down_i(dir_down_i), .repeat_i(repeat_i),
    .acc_i(acc_i), .count_i(count_i), .ptr_bank_i(ptr_bank_i),
    .mem_abort_i(mem_abort_i), .mem_rd_en_o(mem_rd_en_o),
    .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .ptr_o(ptr_o), .count_o(count_o), .flags_o(flags_o),
    .cycles_o(cycles_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [5:0] mflags = '0;   // model flags {S,Z,H,V,N,C}

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference behaviour built from the requirements
  task automatic model(input int sel, input bit wd, input bit dn, input bit rp,
                       input logic [15:0] acc, input logic [15:0] cnt, input bit ab,
                       output logic [AW-1:0] e_ptr, output logic [15:0] e_cnt,
                       output logic [CYCW-1:0] e_cyc);
    logic [AW-1:0] p;
    logic [15:0]   c;
    logic [15:0]   op;
    logic [16:0]   d;
    bit            go;
    p = bank[sel];
    c = cnt;
    e_cyc = rp ? 24'd10 : 24'd8;
    go = 1'b1;
    while (go) begin
      op = wd ? {mem[p[9:0] + 10'd1], mem[p[9:0]]} : {8'h00, mem[p[9:0]]};
      if (!ab) begin
        if (wd) begin
          d = {1'b0, acc} - {1'b0, op};
          mflags[5] = d[15];
          mflags[4] = (d[15:0] == 16'h0);
          mflags[0] = d[16];
        end else begin
          d = {9'h0, acc[7:0]} - {9'h0, op[7:0]};
          mflags[5] = d[7];
          mflags[4] = (d[7:0] == 8'h0);
          mflags[0] = d[8];
        end
        mflags[3] = (acc[3:0] < op[3:0]);
        mflags[1] = 1'b1;
      end
      if (dn) p = p - (wd ? 24'd2 : 24'd1);
      else    p = p + (wd ? 24'd2 : 24'd1);
      c = c - 16'd1;
      mflags[2] = (c != 16'h0);
      if (rp) e_cyc = e_cyc + 24'd14;
      go = rp && mflags[2] && !mflags[4];
    end
    e_ptr = p;
    e_cnt = c;
  endtask

  task automatic run_op(input int sel, input bit wd, input bit dn, input bit rp,
                        input logic [15:0] acc, input logic [15:0] cnt, input bit ab,
                        input bit poke, input string tag);
    logic [AW-1:0]   e_ptr;
    logic [15:0]     e_cnt;
    logic [CYCW-1:0] e_cyc;
    int guard;
    model(sel, wd, dn, rp, acc, cnt, ab, e_ptr, e_cnt, e_cyc);
    @(negedge clk);
    ptr_sel_i = 3'(sel); word_i = wd; dir_down_i = dn; repeat_i = rp;
    acc_i = acc; count_i = cnt; mem_abort_i = ab; start_i = 1'b1;
    @(negedge clk);
    if (poke) begin
      // R10: second start while busy with different settings
      start_i = 1'b1; ptr_sel_i = 3'(sel + 1); acc_i = ~acc; word_i = ~wd;
      repeat_i = 1'b0; count_i = 16'h0001;
      @(negedge clk);
    end
    start_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(tag, "done seen", {31'h0, done_o}, 32'h1);
    check(tag, "ptr",    {8'h0, ptr_o},   {8'h0, e_ptr});
    check(tag, "count",  {16'h0, count_o}, {16'h0, e_cnt});
    check(tag, "flags",  {26'h0, flags_o}, {26'h0, mflags});
    check(tag, "cycles", {8'h0, cycles_o}, {8'h0, e_cyc});
    @(negedge clk);
    check("R10", "done pulse width", {31'h0, done_o}, 32'h0);
    mem_abort_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 5);
    for (int k = 0; k < NPTR; k++) bank[k] = 24'(200 + k * 90);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy",   {31'h0, busy_o}, 32'h0);
    check("R1", "done",   {31'h0, done_o}, 32'h0);
    check("R1", "rd_en",  {31'h0, mem_rd_en_o}, 32'h0);
    check("R1", "flags",  {26'h0, flags_o}, 32'h0);
    check("R1", "count",  {16'h0, count_o}, 32'h0);
    check("R1", "ptr",    {8'h0, ptr_o}, 32'h0);
    check("R1", "cycles", {8'h0, cycles_o}, 32'h0);

    // R3 byte single compare with borrow and nibble borrow
    mem[200] = 8'h3C;
    run_op(0, 0, 0, 0, 16'h0021, 16'd5, 0, 0, "R3");
    // R3 byte match sets Z
    mem[290] = 8'h21;
    run_op(1, 0, 0, 0, 16'hFF21, 16'd5, 0, 0, "R3");
    // R4 word compare
    mem[380] = 8'h34; mem[381] = 8'h12;
    run_op(2, 1, 0, 0, 16'h1235, 16'd2, 0, 0, "R4");
    run_op(2, 1, 1, 0, 16'h0F00, 16'd2, 0, 0, "R4");
    // R5 downward wrap past address zero
    bank[3] = 24'h000000;
    run_op(3, 0, 1, 0, 16'h0000, 16'd3, 0, 0, "R5");
    bank[3] = 24'h000001;
    run_op(3, 1, 1, 0, 16'h0000, 16'd3, 0, 0, "R5");
    // R6 count of zero wraps to FFFF with V set
    run_op(4, 0, 0, 0, 16'h0011, 16'd0, 0, 0, "R6");
    // R7 repeat stops on match in third element
    bank[5] = 24'd600;
    mem[600] = 8'h01; mem[601] = 8'h02; mem[602] = 8'h77; mem[603] = 8'h77;
    run_op(5, 0, 0, 1, 16'h0077, 16'd10, 0, 0, "R7");
    // R7 repeat exhausts count without match
    for (int i = 0; i < 8; i++) mem[650 + i] = 8'h10;
    bank[6] = 24'd650;
    run_op(6, 0, 0, 1, 16'h0099, 16'd6, 0, 0, "R7");
    // R8 repeat of one step costs 24
    run_op(6, 0, 0, 1, 16'h0099, 16'd1, 0, 0, "R8");
    // R7 word repeat downward
    run_op(6, 1, 1, 1, 16'h1010, 16'd4, 0, 0, "R7");
    // R9 abort with Z held at 1: stops after one step
    run_op(5, 0, 0, 0, 16'h0001, 16'd3, 0, 0, "R9");
    run_op(6, 0, 0, 1, 16'h0099, 16'd5, 1, 0, "R9");
    // R9 abort with Z held at 0: runs the full count
    run_op(6, 0, 0, 0, 16'h0099, 16'd3, 0, 0, "R9");
    run_op(6, 0, 0, 1, 16'h0099, 16'd5, 1, 0, "R9");
    // R10 start while busy ignored
    run_op(6, 0, 0, 1, 16'h0099, 16'd6, 0, 1, "R10");

    // Random mix over small value range
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom_range(0, 7));
    for (int k = 0; k < NPTR; k++) bank[k] = 24'($urandom_range(100, 900));
    for (int t = 0; t < 70; t++) begin
      bit wd, dn, rp, ab;
      logic [15:0] acc;
      wd = 1'($urandom_range(0, 1));
      dn = 1'($urandom_range(0, 1));
      rp = ($urandom_range(0, 3) != 0);
      ab = ($urandom_range(0, 7) == 0);
      acc = {8'($urandom_range(0, 7)), 8'($urandom_range(0, 7))};
      run_op(int'($urandom_range(0, 7)), wd, dn, rp, acc,
             16'($urandom_range(1, 24)), ab, 0, wd ? "R4" : "R3");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule